// File: doc/BRIEF.md
# Transmit FIFO Underrun Recovery Logic

This block sits between a host-written transmit data FIFO and a line-rate frame serializer. It is meant for the cut-through path, where the serializer may start a frame before the host has written all of it. Each host word carries start-of-frame and end-of-frame marks. Each time the line side strobes for a word, the block checks whether the FIFO is empty. If the FIFO is empty in the middle of a frame, the block abandons that frame. It stops feeding the line and posts a status word that carries an underrun indication. It also sets a sticky underrun flag, which software clears by writing 1.

An underrun is not treated as a fault. The host keeps writing the rest of the abandoned frame. Those words stay in the FIFO, the occupancy count shows them, and the read side stays closed. The read side opens again only when software pulses the dump command. A dump empties the FIFO in one cycle, and the transmitter enable may stay high while it happens. The next frame after the dump is sent normally, whether or not the sticky flag has been cleared. In store-and-forward mode an empty FIFO in the middle of a frame only stalls the read side.

Top module: `tx_underrun_guard`

## Requirements
- R1: While reset is asserted and after its release, level_o is 0, wr_full_o is 0, rd_valid_o is 0, sts_valid_o is 0 and int_unf_o is 0.
- R2: Host words are stored with wr_sof_i/wr_eof_i marks and leave in write order. A granted read strobe at one clock edge produces rd_valid_o with the word and its marks after that edge. The word carrying the end mark also produces a one-cycle sts_valid_o with sts_unf_o=0 and sts_len_o equal to the number of words in the frame.
- R3: In cut-through mode (sf_mode_i=0), a read strobe inside a frame while the FIFO is empty produces no word. It produces sts_valid_o with sts_unf_o=1 and sts_len_o equal to the words already sent, and int_unf_o goes to 1 in the same cycle.
- R4: After an underrun, further host writes accumulate and level_o counts them. No word is delivered on any read strobe until a dump, even if a start-marked word is queued.
- R5: A dump_i pulse sets level_o to 0 after the edge and reopens the read side for a new frame. It is accepted while tx_en_i is 1. A write or read strobe in the same cycle as the dump has no effect.
- R6: After a dump, the next start-marked frame is delivered in full with sts_unf_o=0, whether or not int_unf_o has been cleared.
- R7: In store-and-forward mode (sf_mode_i=1), an empty FIFO inside a frame only stalls the read side, with no status and no flag. The frame continues once data arrives.
- R8: int_unf_o is sticky and is cleared by unf_clr_i=1. If an underrun happens in the same cycle as a clear, the flag is set.
- R9: A read strobe while tx_en_i=0, or between frames while the FIFO is empty, delivers nothing and raises no underrun. The queued data stays in place.
- R10: With level_o equal to DEPTH, wr_full_o is 1 and host writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable; read strobes are ignored while low |
| sf_mode_i | input | 1 | 1 = store-and-forward, 0 = cut-through |
| wr_valid_i | input | 1 | Host write strobe |
| wr_data_i | input | DW | Host write word |
| wr_sof_i | input | 1 | Write word starts a frame |
| wr_eof_i | input | 1 | Write word ends a frame |
| wr_full_o | output | 1 | FIFO holds DEPTH words |
| level_o | output | $clog2(DEPTH+1) | FIFO occupancy |
| rd_req_i | input | 1 | Line-side read strobe |
| rd_valid_o | output | 1 | Word delivered to the line this cycle |
| rd_data_o | output | DW | Delivered word |
| rd_sof_o | output | 1 | Delivered word starts the frame |
| rd_eof_o | output | 1 | Delivered word ends the frame |
| dump_i | input | 1 | Flush pulse: empty the FIFO and reopen the read side |
| sts_valid_o | output | 1 | Frame status word valid (one cycle) |
| sts_unf_o | output | 1 | Status: frame ended by underrun |
| sts_len_o | output | LW | Status: words sent for the frame |
| int_unf_o | output | 1 | Sticky underrun flag |
| unf_clr_i | input | 1 | Write-1-to-clear for int_unf_o |

## Verification
The bench starves a frame after two words. It then checks that the words written afterwards only raise the occupancy, and that a start-marked word queued behind them stays blocked. A design that kept reading, or skipped ahead to the next start mark, would leak the stale tail or a later frame onto the line. The dump is issued while the enable is high and in the same cycle as a write and a read strobe. A design that let either of these through would leave a nonzero level or deliver a word. The bench also runs the store-and-forward stall, which must not be reported as an underrun. It runs a clear that coincides with a new underrun, where a design that gave the clear priority would lose the flag. Finally it fills the FIFO and pushes one more word. A design that overwrote data would corrupt the sixteen delivered words or the underrun length.

// File: rtl/txu_pkg.sv
package txu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_PARK = 2'd2
  } txu_state_e;

  typedef struct packed {
    logic sof;
    logic eof;
  } txu_mark_t;
endpackage

// File: rtl/txu_fifo.sv
module txu_fifo #(
  parameter int EW    = 10,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [EW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [EW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] level_o
);
  logic [EW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q, wptr_inc, rptr_inc;
  logic [CW-1:0] level_q;
  logic          push_ok, pop_ok;

  assign full_o   = (level_q == CW'(DEPTH));
  assign empty_o  = (level_q == '0);
  assign push_ok  = push_i & ~full_o & ~flush_i;
  assign pop_ok   = pop_i & ~empty_o & ~flush_i;
  assign head_o   = mem_q[rptr_q];
  assign level_o  = level_q;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wptr_inc = wptr_q + 1'b1;
      assign rptr_inc = rptr_q + 1'b1;
    end else begin : g_wrap
      assign wptr_inc = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      assign rptr_inc = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_inc;
      if (pop_ok)  rptr_q <= rptr_inc;
      unique case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/txu_frame_ctl.sv
module txu_frame_ctl
  import txu_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic          sf_mode_i,
  input  logic          rd_req_i,
  input  logic          dump_i,
  input  logic          empty_i,
  input  logic [DW+1:0] head_i,
  output logic          pop_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_sof_o,
  output logic          rd_eof_o,
  output logic          fin_o,
  output logic          fin_unf_o,
  output logic [LW-1:0] fin_len_o
);
  txu_state_e    st_q, st_d;
  logic [LW-1:0] cnt_q, cnt_d;
  txu_mark_t     hm;
  logic          req;

  assign hm  = txu_mark_t'(head_i[DW+1:DW]);
  assign req = rd_req_i & tx_en_i & ~dump_i;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    pop_o     = 1'b0;
    fin_o     = 1'b0;
    fin_unf_o = 1'b0;
    fin_len_o = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        // only a start-marked head opens a frame
        if (req && !empty_i && hm.sof) begin
          pop_o = 1'b1;
          cnt_d = LW'(1);
          if (hm.eof) begin
            fin_o     = 1'b1;
            fin_len_o = LW'(1);
          end else begin
            st_d = ST_SEND;
          end
        end
      end
      ST_SEND: begin
        if (req) begin
          if (!empty_i) begin
            pop_o = 1'b1;
            cnt_d = cnt_q + LW'(1);
            if (hm.eof) begin
              fin_o     = 1'b1;
              fin_len_o = cnt_q + LW'(1);
              st_d      = ST_IDLE;
            end
          end else if (!sf_mode_i) begin
            fin_o     = 1'b1;
            fin_unf_o = 1'b1;
            st_d      = ST_PARK;
          end
        end
      end
      ST_PARK: st_d = ST_PARK;
      default: st_d = ST_IDLE;
    endcase
    if (dump_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      rd_sof_o   <= 1'b0;
      rd_eof_o   <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      rd_valid_o <= pop_o;
      if (pop_o) begin
        rd_data_o <= head_i[DW-1:0];
        rd_sof_o  <= hm.sof;
        rd_eof_o  <= hm.eof;
      end
    end
  end
endmodule

// File: rtl/txu_status.sv
module txu_status #(
  parameter int LW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fin_i,
  input  logic          fin_unf_i,
  input  logic [LW-1:0] fin_len_i,
  input  logic          unf_clr_i,
  output logic          sts_valid_o,
  output logic          sts_unf_o,
  output logic [LW-1:0] sts_len_o,
  output logic          int_unf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_valid_o <= 1'b0;
      sts_unf_o   <= 1'b0;
      sts_len_o   <= '0;
      int_unf_o   <= 1'b0;
    end else begin
      sts_valid_o <= fin_i;
      if (fin_i) begin
        sts_unf_o <= fin_unf_i;
        sts_len_o <= fin_len_i;
      end
      // set beats clear
      if (fin_i && fin_unf_i) int_unf_o <= 1'b1;
      else if (unf_clr_i)     int_unf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_underrun_guard.sv
module tx_underrun_guard #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int LW    = 12,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic          sf_mode_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_sof_i,
  input  logic          wr_eof_i,
  output logic          wr_full_o,
  output logic [CW-1:0] level_o,
  input  logic          rd_req_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_sof_o,
  output logic          rd_eof_o,
  input  logic          dump_i,
  output logic          sts_valid_o,
  output logic          sts_unf_o,
  output logic [LW-1:0] sts_len_o,
  output logic          int_unf_o,
  input  logic          unf_clr_i
);
  localparam int EW = DW + 2;

  logic [EW-1:0] head;
  logic          empty, pop;
  logic          fin, fin_unf;
  logic [LW-1:0] fin_len;

  txu_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (dump_i),
    .push_i      (wr_valid_i),
    .push_data_i ({wr_sof_i, wr_eof_i, wr_data_i}),
    .pop_i       (pop),
    .head_o      (head),
    .empty_o     (empty),
    .full_o      (wr_full_o),
    .level_o     (level_o)
  );

  txu_frame_ctl #(.DW(DW), .LW(LW)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_en_i    (tx_en_i),
    .sf_mode_i  (sf_mode_i),
    .rd_req_i   (rd_req_i),
    .dump_i     (dump_i),
    .empty_i    (empty),
    .head_i     (head),
    .pop_o      (pop),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .rd_sof_o   (rd_sof_o),
    .rd_eof_o   (rd_eof_o),
    .fin_o      (fin),
    .fin_unf_o  (fin_unf),
    .fin_len_o  (fin_len)
  );

  txu_status #(.LW(LW)) u_sts (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fin_i       (fin),
    .fin_unf_i   (fin_unf),
    .fin_len_i   (fin_len),
    .unf_clr_i   (unf_clr_i),
    .sts_valid_o (sts_valid_o),
    .sts_unf_o   (sts_unf_o),
    .sts_len_o   (sts_len_o),
    .int_unf_o   (int_unf_o)
  );
endmodule

// File: rtl/txu_chk.sv
module txu_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_en_i,
  input logic          sf_mode_i,
  input logic          rd_req_i,
  input logic          dump_i,
  input logic          rd_valid_o,
  input logic [CW-1:0] level_o,
  input logic          sts_valid_o,
  input logic          sts_unf_o,
  input logic          int_unf_o
);
  logic parked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        parked_q <= 1'b0;
    else if (dump_i)                    parked_q <= 1'b0;
    else if (sts_valid_o && sts_unf_o)  parked_q <= 1'b1;
  end

  // R2
  rd_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i && tx_en_i && !dump_i));

  // R5
  dump_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_i |=> (level_o == '0));

  // R3
  flag_on_unf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_valid_o && sts_unf_o) |-> int_unf_o);

  // R8
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_unf_o) |-> (sts_valid_o && sts_unf_o));

  // R4
  parked_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parked_q |-> !rd_valid_o);

  // R7
  sf_no_unf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_valid_o && sts_unf_o) |-> $past(!sf_mode_i));

  // R10
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH));
endmodule

bind tx_underrun_guard txu_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_en_i     (tx_en_i),
  .sf_mode_i   (sf_mode_i),
  .rd_req_i    (rd_req_i),
  .dump_i      (dump_i),
  .rd_valid_o  (rd_valid_o),
  .level_o     (level_o),
  .sts_valid_o (sts_valid_o),
  .sts_unf_o   (sts_unf_o),
  .int_unf_o   (int_unf_o)
);

// File: tb/sim_tx_underrun_guard.sv
module sim_tx_underrun_guard;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int LW    = 12;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tx_en_i = 1'b1, sf_mode_i = 1'b0;
  logic          wr_valid_i = 1'b0, wr_sof_i = 1'b0, wr_eof_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          wr_full_o;
  logic [CW-1:0] level_o;
  logic          rd_req_i = 1'b0;
  logic          rd_valid_o, rd_sof_o, rd_eof_o;
  logic [DW-1:0] rd_data_o;
  logic          dump_i = 1'b0;
  logic          sts_valid_o, sts_unf_o, int_unf_o;
  logic [LW-1:0] sts_len_o;
  logic          unf_clr_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tx_underrun_guard #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .sf_mode_i(sf_mode_i),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_sof_i(wr_sof_i),
    .wr_eof_i(wr_eof_i), .wr_full_o(wr_full_o), .level_o(level_o),
    .rd_req_i(rd_req_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .rd_sof_o(rd_sof_o), .rd_eof_o(rd_eof_o), .dump_i(dump_i),
    .sts_valid_o(sts_valid_o), .sts_unf_o(sts_unf_o), .sts_len_o(sts_len_o),
    .int_unf_o(int_unf_o), .unf_clr_i(unf_clr_i)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic sof, input logic eof, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_sof_i = sof; wr_eof_i = eof; wr_data_i = d;
    @(negedge clk);
    wr_valid_i = 1'b0; wr_sof_i = 1'b0; wr_eof_i = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk);
    rd_req_i = 1'b1;
    @(negedge clk);
    rd_req_i = 1'b0;
  endtask

  task automatic dump();
    @(negedge clk);
    dump_i = 1'b1;
    @(negedge clk);
    dump_i = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk);
    unf_clr_i = 1'b1;
    @(negedge clk);
    unf_clr_i = 1'b0;
  endtask

  task automatic rd_expect(input string req, input logic [DW-1:0] d, input logic sof, input logic eof);
    rd();
    chk(req, "rd_valid", rd_valid_o, 1);
    chk(req, "rd_data", rd_data_o, d);
    chk(req, "rd_sof", rd_sof_o, sof);
    chk(req, "rd_eof", rd_eof_o, eof);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1", "level in reset", level_o, 0);
    chk("R1", "rd_valid in reset", rd_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "level", level_o, 0);
    chk("R1", "full", wr_full_o, 0);
    chk("R1", "sts_valid", sts_valid_o, 0);
    chk("R1", "int_unf", int_unf_o, 0);
  endtask

  task automatic t_normal();
    push(1'b1, 1'b0, 8'hA0);
    push(1'b0, 1'b0, 8'hA1);
    push(1'b0, 1'b1, 8'hA2);
    chk("R2", "level after 3 writes", level_o, 3);
    rd_expect("R2", 8'hA0, 1'b1, 1'b0);
    chk("R2", "no status mid frame", sts_valid_o, 0);
    rd_expect("R2", 8'hA1, 1'b0, 1'b0);
    rd_expect("R2", 8'hA2, 1'b0, 1'b1);
    chk("R2", "sts_valid at eof", sts_valid_o, 1);
    chk("R2", "sts_unf at eof", sts_unf_o, 0);
    chk("R2", "sts_len", sts_len_o, 3);
    chk("R2", "level drained", level_o, 0);
  endtask

  task automatic t_idle();
    rd();
    chk("R9", "rd_valid on empty idle", rd_valid_o, 0);
    chk("R9", "no status on empty idle", sts_valid_o, 0);
    chk("R9", "no flag on empty idle", int_unf_o, 0);
    push(1'b1, 1'b1, 8'h11);
    tx_en_i = 1'b0;
    rd();
    chk("R9", "rd_valid with tx_en low", rd_valid_o, 0);
    chk("R9", "level kept with tx_en low", level_o, 1);
    tx_en_i = 1'b1;
    rd_expect("R9", 8'h11, 1'b1, 1'b1);
    chk("R9", "single word frame len", sts_len_o, 1);
  endtask

  task automatic t_underrun();
    push(1'b1, 1'b0, 8'hB0);
    push(1'b0, 1'b0, 8'hB1);
    rd_expect("R3", 8'hB0, 1'b1, 1'b0);
    rd_expect("R3", 8'hB1, 1'b0, 1'b0);
    rd();
    chk("R3", "rd_valid on starved read", rd_valid_o, 0);
    chk("R3", "sts_valid on underrun", sts_valid_o, 1);
    chk("R3", "sts_unf on underrun", sts_unf_o, 1);
    chk("R3", "sts_len on underrun", sts_len_o, 2);
    chk("R3", "int_unf set", int_unf_o, 1);
    push(1'b0, 1'b0, 8'hB2);
    push(1'b0, 1'b1, 8'hB3);
    chk("R4", "level counts parked words", level_o, 2);
    push(1'b1, 1'b1, 8'hC0);
    chk("R4", "level with queued frame", level_o, 3);
    rd();
    chk("R4", "rd_valid while parked", rd_valid_o, 0);
    rd();
    chk("R4", "rd_valid while parked again", rd_valid_o, 0);
    chk("R4", "level untouched while parked", level_o, 3);
    // dump with tx_en high, plus same-cycle write and read strobe
    @(negedge clk);
    dump_i = 1'b1; rd_req_i = 1'b1;
    wr_valid_i = 1'b1; wr_sof_i = 1'b1; wr_eof_i = 1'b1; wr_data_i = 8'hCC;
    @(negedge clk);
    dump_i = 1'b0; rd_req_i = 1'b0;
    wr_valid_i = 1'b0; wr_sof_i = 1'b0; wr_eof_i = 1'b0;
    chk("R5", "level after dump", level_o, 0);
    chk("R5", "rd_valid on dump cycle", rd_valid_o, 0);
    rd();
    chk("R5", "dropped write not delivered", rd_valid_o, 0);
    chk("R8", "flag sticky through dump", int_unf_o, 1);
  endtask

  task automatic t_resume();
    push(1'b1, 1'b0, 8'hD0);
    push(1'b0, 1'b1, 8'hD1);
    rd_expect("R6", 8'hD0, 1'b1, 1'b0);
    rd_expect("R6", 8'hD1, 1'b0, 1'b1);
    chk("R6", "sts_unf after resume", sts_unf_o, 0);
    chk("R6", "sts_len after resume", sts_len_o, 2);
    chk("R6", "flag still set", int_unf_o, 1);
  endtask

  task automatic t_clear();
    clr();
    chk("R8", "flag cleared", int_unf_o, 0);
    push(1'b1, 1'b0, 8'hE0);
    rd_expect("R8", 8'hE0, 1'b1, 1'b0);
    @(negedge clk);
    rd_req_i = 1'b1; unf_clr_i = 1'b1;
    @(negedge clk);
    rd_req_i = 1'b0; unf_clr_i = 1'b0;
    chk("R8", "underrun status with clear", sts_unf_o, 1);
    chk("R8", "set wins over clear", int_unf_o, 1);
    dump();
    clr();
    chk("R8", "flag cleared again", int_unf_o, 0);
  endtask

  task automatic t_sf();
    sf_mode_i = 1'b1;
    push(1'b1, 1'b0, 8'hF0);
    rd_expect("R7", 8'hF0, 1'b1, 1'b0);
    rd();
    chk("R7", "stall gives no word", rd_valid_o, 0);
    chk("R7", "stall gives no status", sts_valid_o, 0);
    chk("R7", "stall sets no flag", int_unf_o, 0);
    push(1'b0, 1'b1, 8'hF1);
    rd_expect("R7", 8'hF1, 1'b0, 1'b1);
    chk("R7", "sts_unf after stall", sts_unf_o, 0);
    chk("R7", "sts_len after stall", sts_len_o, 2);
    sf_mode_i = 1'b0;
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) push(i == 0, 1'b0, 8'h40 + 8'(i));
    chk("R10", "full flag", wr_full_o, 1);
    chk("R10", "level at depth", level_o, DEPTH);
    push(1'b0, 1'b1, 8'hEE);
    chk("R10", "level after write to full", level_o, DEPTH);
    for (int i = 0; i < DEPTH; i++) rd_expect("R10", 8'h40 + 8'(i), i == 0, 1'b0);
    rd();
    chk("R10", "extra write absent", rd_valid_o, 0);
    chk("R10", "underrun after 16", sts_unf_o, 1);
    chk("R10", "len after 16", sts_len_o, DEPTH);
    dump();
    clr();
  endtask

  initial begin
    t_reset();
    t_normal();
    t_idle();
    t_underrun();
    t_resume();
    t_clear();
    t_sf();
    t_full();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule